// File: doc/BRIEF.md
# Parity-Protected MMU Configuration Register Array

The block holds sixteen 64-bit MMU configuration registers behind a synchronous host register port. Each response arrives one cycle after its request. The registers are grouped into eight protected entries, two registers per entry, and each entry carries a single even-parity bit computed over the 128 bits of both its registers. Because the two registers share one parity bit, corruption in either register is seen whenever either register of that entry is accessed.

Entries 0 to 3 each pair two neighbouring context-zero table-configuration registers that sit 8 bytes apart. Entries 4 to 7 each pair a real-range register with the physical-offset register located 0x100 above it. Offset bits 9:8 select the register group.

The same port reaches four control and status words:
- an injection control word, which can make every committed write store bad parity;
- a detection enable word, which holds two independent gates that must both be set before a fault is reported;
- a fault type register;
- a fault entry register.

When a fault is detected, the access responds with a one-cycle error pulse. If the access was a store, it is dropped. Any committed write rewrites the entry's parity. A clean write therefore repairs the entry for both of its registers.

Top module: `mmu_parity_regarray`

## Requirements
- R1: After reset every array register, every parity bit, both injection bits, both detection enables and both status registers are zero, and `resp_valid` is low until the first request.
- R2: A request on a cycle with `req_valid` high gets its response on the next cycle with `resp_valid` high. Reads of array registers return the stored value and writes return zero data. The offsets are: table-configuration registers at 0x000 to 0x038 in steps of 8 (entry = offset bits 5:4); real-range registers at 0x108 to 0x120 (entries 4 to 7 in ascending order); physical-offset registers at 0x208 to 0x220 (entries 4 to 7, each paired with the real-range register 0x100 below it).
- R3: An access to any other offset, or to any offset not a multiple of 8, returns zero, never raises an error and changes no register.
- R4: The injection control word is at 0x300. Bit 0 is the mask bit and bit 1 is the injection enable. Only when both bits are 1 does a committed array write store inverted parity for its entry. With either bit clear, a committed write stores correct parity.
- R5: The detection word is at 0x308. Bit 0 is the array-error enable and bit 1 is the precise-trap enable. With both set, a read or write of either register of an entry whose parity is bad returns `resp_err` high for exactly that response, with zero read data.
- R6: A write that raises an error does not change any register.
- R7: On a detected fault, the fault type register at 0x310 takes the value 7 in its low 4 bits and the fault entry register at 0x318 takes the entry index in its low 3 bits. A write to either register loads its low bits from the write data, so writing zero clears it.
- R8: If either detection enable is 0, an access to a faulty entry raises no error and a write is committed.
- R9: A committed write with injection off recomputes even parity over the new value and the partner register's current value, so later accesses to either register of that entry raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (10) | Byte offset of the register |
| req_wdata | input | DW (64) | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_rdata | output | DW (64) | Read data, zero for writes, errors and unmapped offsets |
| resp_err | output | 1 | One-cycle error pulse for a detected parity fault |

## Verification
The bench builds the block with its default parameters: 64-bit registers and a 10-bit offset. At these values the full map is reachable: all three register groups, the unmapped gaps between them, and the control words in the top group. The behavioural model tracks a per-entry "corrupted" flag rather than parity bits. This lets the bench exercise:
- cross-register detection in both group pairings;
- each enable gate on its own;
- each injection bit on its own;
- store suppression;
- repair of an entry by a clean write.

// File: rtl/mmu_parity_regarray_pkg.sv
package mmu_parity_regarray_pkg;

    localparam int unsigned NUM_ENTRY = 8;
    localparam int unsigned NUM_SLOT  = 2 * NUM_ENTRY;
    localparam int unsigned SLOT_W    = $clog2(NUM_SLOT);
    localparam int unsigned ENT_W     = $clog2(NUM_ENTRY);
    localparam logic [3:0]  FAULT_CODE = 4'd7;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ARRAY,
        ACC_INJ,
        ACC_DET,
        ACC_FTYPE,
        ACC_FENT
    } acc_kind_e;

endpackage

// File: rtl/mmu_parity_regarray_decode.sv
module mmu_parity_regarray_decode
    import mmu_parity_regarray_pkg::*;
#(
    parameter int unsigned AW = 10
) (
    input  logic [AW-1:0]     addr,
    output acc_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);
    logic [1:0] grp_w;
    logic [7:0] low_w;
    logic       aligned_w;
    logic       hi_zero_w;
    logic [2:0] pair_idx_w;

    assign grp_w      = addr[9:8];
    assign low_w      = addr[7:0];
    assign aligned_w  = (addr[2:0] == 3'd0);
    assign pair_idx_w = low_w[5:3] - 3'd1;

    generate
        if (AW > 10) begin : g_wide
            assign hi_zero_w = (addr[AW-1:10] == '0);
        end else begin : g_exact
            assign hi_zero_w = 1'b1;
        end
    endgenerate

    always_comb begin
        kind = ACC_NONE;
        slot = '0;
        if (aligned_w && hi_zero_w) begin
            unique case (grp_w)
                2'd0: if (low_w < 8'h40) begin
                    kind = ACC_ARRAY;
                    slot = {1'b0, low_w[5:3]};
                end
                2'd1, 2'd2: if (low_w >= 8'h08 && low_w <= 8'h20) begin
                    kind = ACC_ARRAY;
                    slot = {1'b1, pair_idx_w[1:0], grp_w[1]};
                end
                default: begin
                    unique case (low_w)
                        8'h00:   kind = ACC_INJ;
                        8'h08:   kind = ACC_DET;
                        8'h10:   kind = ACC_FTYPE;
                        8'h18:   kind = ACC_FENT;
                        default: kind = ACC_NONE;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/mmu_parity_regarray.sv
module mmu_parity_regarray
    import mmu_parity_regarray_pkg::*;
#(
    parameter int unsigned DW = 64,
    parameter int unsigned AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          resp_valid,
    output logic [DW-1:0] resp_rdata,
    output logic          resp_err
);
    typedef struct packed {
        logic [NUM_SLOT-1:0][DW-1:0] regs;
        logic [NUM_ENTRY-1:0]        par;
        logic                        inj_mask;
        logic                        inj_on;
        logic                        det_arr;
        logic                        det_trap;
        logic [3:0]                  ftype;
        logic [ENT_W-1:0]            fent;
        logic                        rvalid;
        logic                        rerr;
        logic [DW-1:0]               rdata;
    } state_t;

    state_t st_d, st_q;

    acc_kind_e            kind_w;
    logic [SLOT_W-1:0]    slot_w;
    logic [ENT_W-1:0]     ent_w;
    logic [NUM_ENTRY-1:0] bad_w;
    logic                 detect_w;
    logic                 inject_w;

    mmu_parity_regarray_decode #(.AW(AW)) u_decode (
        .addr (req_addr),
        .kind (kind_w),
        .slot (slot_w)
    );

    // Each entry is faulty when its stored parity no longer matches its 128 bits.
    generate
        for (genvar e = 0; e < NUM_ENTRY; e++) begin : g_chk
            assign bad_w[e] = st_q.par[e] ^ (^{st_q.regs[2*e+1], st_q.regs[2*e]});
        end
    endgenerate

    assign ent_w    = slot_w[SLOT_W-1:1];
    assign detect_w = bad_w[ent_w] && st_q.det_arr && st_q.det_trap;
    assign inject_w = st_q.inj_on && st_q.inj_mask;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = req_valid;
        st_d.rerr   = 1'b0;
        st_d.rdata  = '0;
        if (req_valid) begin
            unique case (kind_w)
                ACC_ARRAY: begin
                    if (detect_w) begin
                        st_d.rerr  = 1'b1;
                        st_d.ftype = FAULT_CODE;
                        st_d.fent  = ent_w;
                    end else if (req_write) begin
                        st_d.regs[slot_w] = req_wdata;
                        st_d.par[ent_w]   = (^{req_wdata, st_q.regs[slot_w ^ 4'd1]}) ^ inject_w;
                    end else begin
                        st_d.rdata = st_q.regs[slot_w];
                    end
                end
                ACC_INJ: begin
                    if (req_write) begin
                        st_d.inj_mask = req_wdata[0];
                        st_d.inj_on   = req_wdata[1];
                    end else begin
                        st_d.rdata[1:0] = {st_q.inj_on, st_q.inj_mask};
                    end
                end
                ACC_DET: begin
                    if (req_write) begin
                        st_d.det_arr  = req_wdata[0];
                        st_d.det_trap = req_wdata[1];
                    end else begin
                        st_d.rdata[1:0] = {st_q.det_trap, st_q.det_arr};
                    end
                end
                ACC_FTYPE: begin
                    if (req_write) st_d.ftype = req_wdata[3:0];
                    else           st_d.rdata[3:0] = st_q.ftype;
                end
                ACC_FENT: begin
                    if (req_write) st_d.fent = req_wdata[ENT_W-1:0];
                    else           st_d.rdata[ENT_W-1:0] = st_q.fent;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign resp_valid = st_q.rvalid;
    assign resp_rdata = st_q.rdata;
    assign resp_err   = st_q.rerr;

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R5
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> resp_valid && resp_rdata == '0);

    // R8
    err_needs_both_gates_chk: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> $past(st_q.det_arr && st_q.det_trap));

    // R6
    faulty_store_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> st_q.regs == $past(st_q.regs));

    // R7
    fault_code_logged_chk: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> st_q.ftype == FAULT_CODE);
endmodule

// File: tb/mmu_parity_regarray_bench.sv
module mmu_parity_regarray_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr  = '0;
    logic [63:0] req_wdata = '0;
    logic        resp_valid;
    logic [63:0] resp_rdata;
    logic        resp_err;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_tag  = "R1";

    // Behavioural reference state.
    logic [63:0] m_mem [16];
    bit          m_bad [8];
    bit          m_mask, m_on, m_arr, m_trap;
    logic [3:0]  m_ftype;
    logic [2:0]  m_fent;
    logic        e_valid, e_err;
    logic [63:0] e_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_parity_regarray u_mmu_parity_regarray (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_err(resp_err)
    );

    function automatic int slot_of(input logic [9:0] a);
        if (a[2:0] != 0) return -1;
        if (a < 10'h040) return int'(a) / 8;
        if (a >= 10'h108 && a <= 10'h120) return 8 + 2 * ((int'(a) - 'h108) / 8);
        if (a >= 10'h208 && a <= 10'h220) return 9 + 2 * ((int'(a) - 'h208) / 8);
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = '0;
            foreach (m_bad[i]) m_bad[i] = 0;
            {m_mask, m_on, m_arr, m_trap} = '0;
            m_ftype = '0; m_fent = '0;
            e_valid = 0; e_err = 0; e_rdata = '0;
        end else begin
            int s;
            e_valid = req_valid; e_err = 0; e_rdata = '0;
            if (req_valid) begin
                s = slot_of(req_addr);
                if (s >= 0) begin
                    if (m_bad[s/2] && m_arr && m_trap) begin
                        e_err = 1; m_ftype = 4'd7; m_fent = 3'(s/2);
                    end else if (req_write) begin
                        m_mem[s] = req_wdata; m_bad[s/2] = m_mask && m_on;
                    end else begin
                        e_rdata = m_mem[s];
                    end
                end else if (req_addr == 10'h300) begin
                    if (req_write) begin m_mask = req_wdata[0]; m_on = req_wdata[1]; end
                    else e_rdata = {62'd0, m_on, m_mask};
                end else if (req_addr == 10'h308) begin
                    if (req_write) begin m_arr = req_wdata[0]; m_trap = req_wdata[1]; end
                    else e_rdata = {62'd0, m_trap, m_arr};
                end else if (req_addr == 10'h310) begin
                    if (req_write) m_ftype = req_wdata[3:0]; else e_rdata = {60'd0, m_ftype};
                end else if (req_addr == 10'h318) begin
                    if (req_write) m_fent = req_wdata[2:0]; else e_rdata = {61'd0, m_fent};
                end
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (resp_valid !== e_valid || resp_err !== e_err || resp_rdata !== e_rdata) begin
                n_fail++;
                $display("FAIL %s: addr=%h got v=%b e=%b d=%h exp v=%b e=%b d=%h",
                         cur_tag, req_addr, resp_valid, resp_err, resp_rdata,
                         e_valid, e_err, e_rdata);
            end
        end
    end

    task automatic acc(input bit w, input logic [9:0] a, input logic [63:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_tag = "R1";
        idle(1);
        acc(0, 10'h000, 0); acc(0, 10'h218, 0); acc(0, 10'h300, 0);
        acc(0, 10'h308, 0); acc(0, 10'h310, 0); acc(0, 10'h318, 0);

        cur_tag = "R2";
        for (int i = 0; i < 8; i++) acc(1, 10'(i * 8), 64'hA5A5_0000_1234_0000 ^ 64'(i * 7919));
        for (int i = 0; i < 4; i++) begin
            acc(1, 10'h108 + 10'(i * 8), 64'hFFFF_0000_0000_0000 | 64'(i));
            acc(1, 10'h208 + 10'(i * 8), 64'h0123_4567_89AB_CDEF + 64'(i));
        end
        for (int i = 0; i < 8; i++) acc(0, 10'(i * 8), 0);
        for (int i = 0; i < 4; i++) begin acc(0, 10'h108 + 10'(i * 8), 0); acc(0, 10'h208 + 10'(i * 8), 0); end

        cur_tag = "R3";
        acc(0, 10'h040, 0); acc(0, 10'h100, 0); acc(0, 10'h128, 0);
        acc(0, 10'h004, 0); acc(0, 10'h3F8, 0); acc(0, 10'h200, 0);
        acc(1, 10'h040, 64'hDEAD); acc(1, 10'h10C, 64'hBEEF); acc(1, 10'h200, 64'h1);
        acc(0, 10'h000, 0); acc(0, 10'h108, 0);

        cur_tag = "R4";
        acc(1, 10'h308, 3);
        acc(1, 10'h300, 3); acc(0, 10'h300, 0);
        acc(1, 10'h000, 64'h1111);
        acc(1, 10'h300, 0);
        cur_tag = "R5";
        acc(0, 10'h008, 0); acc(0, 10'h000, 0);
        cur_tag = "R7";
        acc(0, 10'h310, 0); acc(0, 10'h318, 0);
        acc(1, 10'h310, 0); acc(0, 10'h310, 0);
        cur_tag = "R6";
        acc(1, 10'h008, 64'h7777); acc(1, 10'h308, 0); acc(0, 10'h008, 0); acc(0, 10'h000, 0);
        acc(1, 10'h308, 3);
        cur_tag = "R9";
        acc(1, 10'h000, 64'h2222); acc(0, 10'h008, 0); acc(0, 10'h000, 0);

        cur_tag = "R5";
        acc(1, 10'h300, 3); acc(1, 10'h110, 64'h5555); acc(1, 10'h300, 0);
        acc(0, 10'h210, 0); acc(1, 10'h110, 64'h6); acc(0, 10'h318, 0);
        cur_tag = "R8";
        acc(1, 10'h308, 1); acc(0, 10'h210, 0); acc(1, 10'h210, 64'hAB);
        acc(1, 10'h308, 3); acc(0, 10'h210, 0); acc(0, 10'h110, 0);
        acc(1, 10'h300, 3); acc(1, 10'h118, 64'h99); acc(1, 10'h300, 0);
        acc(1, 10'h308, 2); acc(0, 10'h218, 0); acc(1, 10'h118, 64'h42);
        acc(1, 10'h308, 3); acc(0, 10'h218, 0); acc(0, 10'h118, 0);
        cur_tag = "R4";
        acc(1, 10'h300, 1); acc(1, 10'h120, 64'hC0); acc(0, 10'h220, 0);
        acc(1, 10'h300, 2); acc(1, 10'h030, 64'hC1); acc(0, 10'h038, 0);
        acc(1, 10'h300, 3); acc(1, 10'h038, 64'hC2); acc(1, 10'h300, 0);
        acc(0, 10'h030, 0); acc(0, 10'h318, 0);
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got hang exp completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule